// File: doc/BRIEF.md
# Horizontal CRT Timing Generator

This block counts character clocks across one horizontal scanline of a character-based CRT controller. From a set of programmed timing fields it produces the display-enable, horizontal-blank and horizontal-sync levels. It also produces a one-character end-of-line pulse for the vertical counter and a per-line flag that tells the memory address logic to start the scanline one address later.

The counter advances only on clocks where `cclk_en` is high. The timing fields are captured into shadow copies on the last character of each line and during reset. A write in the middle of a line therefore changes nothing until the next line begins. Blanking and sync are held in state flags. Each flag is set by a full-width start compare and cleared by a narrow compare on the counter's low bits. This lets either interval run past the end of the line and finish in the next one.

Top module: `htiming`

## Requirements
- R1: While `rst` is high, and on the first clock edges after it, all outputs are low. The character counter restarts at character 0, and the timing inputs present during reset become the active values.
- R2: A line lasts `htotal`+2 enabled character clocks, numbered 0 to `htotal`+1. `line_end` is high only for the character period of character 0, which is the character after every wrap and the first one after reset.
- R3: On clocks where `cclk_en` is low, no output changes and the counter does not advance.
- R4: `disp_en` is high for the characters `de_skew` through `hde_end`+`de_skew`, both inclusive. The skew therefore moves both edges by the same number of characters.
- R5: `hblank` rises at the character equal to `hblk_start`. It falls at the first later character whose low 5 counter bits equal `hblk_end`, and that character may lie in a following line.
- R6: `hsync` rises at the character equal to `hrt_start`+`rt_skew`. It falls at the first later character whose low 5 counter bits equal `hrt_end`, and that character may lie in a following line.
- R7: At character 0 of each line, `addr_bump` takes the value `line_bump` AND NOT `in_split`, and holds that value for the whole line.
- R8: A change to any timing input during a line takes effect from character 0 of the next line. The line in progress keeps its old length and timing.
- R9: When a start compare and an end compare match on the same character, the start wins and the blank or sync level stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cclk_en | input | 1 | Character clock enable |
| htotal | input | 8 | Line length minus 2 |
| hde_end | input | 8 | Last displayed character (inclusive) |
| hblk_start | input | 8 | First blanked character |
| hblk_end | input | 5 | Low-bit match value that ends blanking |
| de_skew | input | 2 | Display-enable delay in characters |
| hrt_start | input | 8 | Sync start character before skew |
| hrt_end | input | 5 | Low-bit match value that ends sync |
| rt_skew | input | 2 | Sync start delay in characters |
| line_bump | input | 1 | Request to offset the line start address by one |
| in_split | input | 1 | Current line is in the split-screen region |
| disp_en | output | 1 | Display enable |
| hblank | output | 1 | Horizontal blank |
| hsync | output | 1 | Horizontal sync |
| line_end | output | 1 | End-of-line pulse for the vertical counter |
| addr_bump | output | 1 | Add one to this line's start address |

## Verification
The hardest cases to reach from the ports are blank and sync intervals that must survive a wrap and end in a later line, and timing writes that land in the middle of a line, where they must wait for the shadow load. The stimulus uses short lines with random end values so that intervals often cross the wrap. It rewrites the timing inputs at random enabled cycles, and directed runs cover a mid-line length change and a start compare that coincides with an end compare.

// File: rtl/htiming.sv
module htiming #(
  parameter int CW  = 8,
  parameter int BEW = 5,
  parameter int REW = 5,
  parameter int SKW = 2
)(
  input  logic           clk,
  input  logic           rst,
  input  logic           cclk_en,
  input  logic [CW-1:0]  htotal,
  input  logic [CW-1:0]  hde_end,
  input  logic [CW-1:0]  hblk_start,
  input  logic [BEW-1:0] hblk_end,
  input  logic [SKW-1:0] de_skew,
  input  logic [CW-1:0]  hrt_start,
  input  logic [REW-1:0] hrt_end,
  input  logic [SKW-1:0] rt_skew,
  input  logic           line_bump,
  input  logic           in_split,
  output logic           disp_en,
  output logic           hblank,
  output logic           hsync,
  output logic           line_end,
  output logic           addr_bump
);
  localparam int NW = CW + 1;

  logic [NW-1:0]  cnt;
  logic [CW-1:0]  s_tot, s_de, s_bs, s_rs;
  logic [BEW-1:0] s_be;
  logic [REW-1:0] s_re;
  logic [SKW-1:0] s_dsk, s_rsk;
  logic           last, de_nxt, blk_nxt, rt_nxt;

  assign last    = cnt == NW'(s_tot) + NW'(1);
  assign de_nxt  = (cnt >= NW'(s_dsk)) && (cnt <= NW'(s_de) + NW'(s_dsk));
  assign blk_nxt = (cnt == NW'(s_bs)) || (hblank && cnt[BEW-1:0] != s_be);
  assign rt_nxt  = (cnt == NW'(s_rs) + NW'(s_rsk)) || (hsync && cnt[REW-1:0] != s_re);

  always_ff @(posedge clk)
    if (rst || (cclk_en && last)) begin
      s_tot <= htotal;
      s_de  <= hde_end;
      s_bs  <= hblk_start;
      s_be  <= hblk_end;
      s_dsk <= de_skew;
      s_rs  <= hrt_start;
      s_re  <= hrt_end;
      s_rsk <= rt_skew;
    end

  always_ff @(posedge clk)
    if (rst) begin
      cnt       <= '0;
      disp_en   <= 1'b0;
      hblank    <= 1'b0;
      hsync     <= 1'b0;
      line_end  <= 1'b0;
      addr_bump <= 1'b0;
    end else if (cclk_en) begin
      cnt      <= last ? '0 : cnt + NW'(1);
      disp_en  <= de_nxt;
      hblank   <= blk_nxt;
      hsync    <= rt_nxt;
      line_end <= cnt == '0;
      if (cnt == '0) addr_bump <= line_bump & ~in_split;
    end
endmodule

// File: rtl/htiming_chk.sv
module htiming_chk (
  input logic clk,
  input logic rst,
  input logic cclk_en,
  input logic disp_en,
  input logic hblank,
  input logic hsync,
  input logic line_end,
  input logic addr_bump
);
  logic rst_d;
  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst_d)
      AST_RST_CLEAR: assert ({disp_en, hblank, hsync, line_end, addr_bump} == 5'b0); // R1
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !cclk_en |=> $stable({disp_en, hblank, hsync, line_end, addr_bump})); // R3

  AST_LINE_END_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (line_end && cclk_en) |=> !line_end); // R2

  AST_BUMP_AT_LINE: assert property (@(posedge clk) disable iff (rst)
    !$stable(addr_bump) |-> ($past(cclk_en) && line_end)); // R7
endmodule

bind htiming htiming_chk u_chk (.*);

// File: tb/htiming_tb.sv
module htiming_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1, cclk_en = 1'b0;
  logic [7:0] htotal, hde_end, hblk_start, hrt_start;
  logic [4:0] hblk_end, hrt_end;
  logic [1:0] de_skew, rt_skew;
  logic line_bump, in_split;
  logic disp_en, hblank, hsync, line_end, addr_bump;

  int n_run = 0, n_fail = 0;
  int m_cnt, s_tot, s_de, s_bs, s_be, s_dsk, s_rs, s_re, s_rsk;
  logic m_de, m_bl, m_rt, m_le, m_ab;

  always #(CLK_PERIOD/2) clk = ~clk;

  htiming u_dut (.*);

  function automatic logic f_de(int c, int dsk, int de_last);
    return (c >= dsk) && (c <= de_last + dsk);
  endfunction

  function automatic logic f_flag(logic prev, int c, int st, int en);
    return (c == st) || (prev && (c % 32) != en);
  endfunction

  task automatic chk(string req, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic load_shadow();
    s_tot = htotal; s_de = hde_end; s_bs = hblk_start; s_be = hblk_end;
    s_dsk = de_skew; s_rs = hrt_start; s_re = hrt_end; s_rsk = rt_skew;
  endtask

  task automatic mstep();
    int c = m_cnt;
    m_de = f_de(c, s_dsk, s_de);
    m_bl = f_flag(m_bl, c, s_bs, s_be);
    m_rt = f_flag(m_rt, c, s_rs + s_rsk, s_re);
    m_le = (c == 0);
    if (c == 0) m_ab = line_bump & ~in_split;
    if (c == s_tot + 1) begin m_cnt = 0; load_shadow(); end
    else m_cnt = c + 1;
  endtask

  task automatic tick(logic en);
    cclk_en = en;
    @(posedge clk);
    if (en) mstep();
    @(negedge clk);
    chk(en ? "R4 disp_en" : "R3 disp_en hold", disp_en, m_de);
    chk(en ? "R5/R9 hblank" : "R3 hblank hold", hblank, m_bl);
    chk(en ? "R6 hsync" : "R3 hsync hold", hsync, m_rt);
    chk(en ? "R2 line_end" : "R3 line_end hold", line_end, m_le);
    chk(en ? "R7 addr_bump" : "R3 addr_bump hold", addr_bump, m_ab);
  endtask

  task automatic do_reset();
    rst = 1'b1; cclk_en = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_cnt = 0; m_de = 0; m_bl = 0; m_rt = 0; m_le = 0; m_ab = 0;
    load_shadow();
    chk("R1 reset outputs", |{disp_en, hblank, hsync, line_end, addr_bump}, 1'b0);
  endtask

  task automatic rand_regs();
    int t = 3 + int'($urandom_range(0, 37));
    htotal     = 8'(t);
    hde_end    = 8'($urandom_range(0, t));
    hblk_start = 8'($urandom_range(0, t + 1));
    hblk_end   = 5'($urandom);
    hrt_start  = 8'($urandom_range(0, t + 1));
    hrt_end    = 5'($urandom);
    de_skew    = 2'($urandom);
    rt_skew    = 2'($urandom);
  endtask

  task automatic set_regs(int t, int de, int bs, int be, int dsk, int rs, int re, int rsk);
    htotal = 8'(t); hde_end = 8'(de); hblk_start = 8'(bs); hblk_end = 5'(be);
    de_skew = 2'(dsk); hrt_start = 8'(rs); hrt_end = 5'(re); rt_skew = 2'(rsk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int cnt_ticks;
    void'($urandom(32'd20240611));
    line_bump = 1'b1; in_split = 1'b0;

    // R8: length change mid-line waits for the wrap; R2 line length
    set_regs(10, 5, 7, 2, 0, 8, 1, 0);
    do_reset();
    for (int i = 0; i < 3; i++) tick(1'b1);
    htotal = 8'd5;
    cnt_ticks = 0;
    do begin tick(1'b1); cnt_ticks++; end while (!line_end && cnt_ticks < 100);
    chk("R8 old line length kept", cnt_ticks == 10, 1'b1);
    cnt_ticks = 0;
    do begin tick(1'b1); cnt_ticks++; end while (!line_end && cnt_ticks < 100);
    chk("R2 new line length 7", cnt_ticks == 7, 1'b1);

    // R9: start and end coincide, blank never drops
    set_regs(20, 10, 4, 4, 3, 6, 6, 3);
    do_reset();
    for (int i = 0; i < 70; i++) tick(1'b1);
    chk("R9 hblank held by start priority", hblank, 1'b1);

    // R5 wrap: blank ends in the next line
    set_regs(9, 6, 8, 3, 1, 2, 5, 2);
    do_reset();
    for (int i = 0; i < 14; i++) tick(1'b1);
    chk("R5 blank crosses wrap", hblank, 1'b1);
    tick(1'b1);
    chk("R5 blank ends at low-bit match", hblank, 1'b0);

    // R7 split region suppresses the bump
    in_split = 1'b1;
    for (int i = 0; i < 20; i++) tick(1'b1);
    chk("R7 bump off in split", addr_bump, 1'b0);
    in_split = 1'b0;

    // R3 long idle stretch
    for (int i = 0; i < 30; i++) tick(1'b0);

    // random phase
    rand_regs();
    do_reset();
    for (int i = 0; i < 8000; i++) begin
      if ($urandom_range(0, 24) == 0) rand_regs();
      if ($urandom_range(0, 15) == 0) line_bump = 1'($urandom);
      if ($urandom_range(0, 15) == 0) in_split = 1'($urandom);
      tick($urandom_range(0, 9) < 7);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule